// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Beat Order

This block produces the address for every beat of a four-beat burst into a synchronous burst memory. A burst begins when either of two start strobes is seen at a rising clock edge. One strobe comes from a processor and the other from a cache controller. At that edge the block captures the whole external address. From then on, each edge at which the step input is high moves the low two address bits to the next beat. The bits above them stay where they were captured.

Beats can come in one of two orders, and a static order strap picks which. A low strap gives a wrapping linear count. A high strap gives an interleaved order, in which the start offset is XORed with a running beat number. Boards that want interleaved order tie the strap high. The strap must not change while bursts are in progress.

Every input is sampled at the rising edge, and the output address is held in registers. A change on the inputs therefore shows up on `burst_addr` after the next rising edge. The ports are plain control and address pins. There is no valid/ready handshake, because no data stream passes through the block and nothing can apply back-pressure to it.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first strobe, `burst_addr` is all zeros.
- R2: At an edge where `start_cpu` or `start_ctl` (or both) is high, `burst_addr` takes the value of `ext_addr` after that edge, and the beat number restarts at 0.
- R3: With `order_ilv` = 0 (linear), each edge with `step` high and no strobe sets the low two bits to the old low bits plus 1, modulo 4. Beat k of a burst starting at offset s is (s + k) mod 4.
- R4: With `order_ilv` = 1 (interleaved), beat k of a burst starting at offset s has low bits s XOR (k mod 4). For example, start 01 gives 01, 00, 11, 10.
- R5: At an edge with no strobe and `step` low, `burst_addr` keeps its value.
- R6: Between strobes, bits above bit 1 of `burst_addr` keep the value captured by the last strobe.
- R7: A strobe overrides `step` and restarts the burst from `ext_addr`, even in the middle of a sequence.
- R8: The sequence wraps. After four steps the low bits are back at the start offset, and stepping continues around the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| order_ilv | input | 1 | Static order strap: 0 = linear, 1 = interleaved |
| start_cpu | input | 1 | Processor-side burst start strobe |
| start_ctl | input | 1 | Controller-side burst start strobe |
| step | input | 1 | Advance to the next beat |
| ext_addr | input | ADDR_W | External address, captured when a strobe is high |
| burst_addr | output | ADDR_W | Current beat address |

## Verification
The hardest case to reach from the ports is a strobe that arrives in the middle of a burst while `step` is also high. The restart has to win over the step, and the beat number has to return to 0. This matters most in interleaved order, where a stale beat number would go unnoticed until the next step. The bench reaches this case by stepping partway through a burst and then raising a strobe together with `step`. It then keeps stepping so that the new beat sequence is checked from a fresh start. The bench also sweeps every start offset, both orders and both strobes, with idle edges inserted partway through each burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_trigger.sv
module burst_trigger (
  input  logic start_cpu,
  input  logic start_ctl,
  input  logic step,
  output logic load,
  output logic adv
);
  // A strobe takes priority over the step input (R7).
  assign load = start_cpu | start_ctl;
  assign adv  = step & ~load;
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [BEAT_W-1:0] start_in,
  output logic [BEAT_W-1:0] start_q,
  output logic [BEAT_W-1:0] beat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      start_q <= start_in;
      beat_q  <= '0;
    end else if (adv) begin
      beat_q  <= beat_q + 1'b1;   // natural wrap modulo 2**BEAT_W (R8)
    end
  end

  // R2: the beat number restarts at zero after a load
  a_r2_beat_restart: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (beat_q == '0));
  // R5: the beat number holds when nothing happens
  a_r5_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(beat_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  order_e            order,
  input  logic [BEAT_W-1:0] start_off,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] low_out
);
  always_comb begin
    unique case (order)
      ORD_LINEAR:     low_out = start_off + beat;
      ORD_INTERLEAVE: low_out = start_off ^ beat;
      default:        low_out = start_off;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              order_ilv,
  input  logic              start_cpu,
  input  logic              start_ctl,
  input  logic              step,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] burst_addr
);
  localparam int BEAT_W = 2;
  localparam int UP_W   = ADDR_W - BEAT_W;

  logic              load, adv;
  logic [BEAT_W-1:0] start_q, beat_q, low_out;
  logic [UP_W-1:0]   upper_q;

  burst_trigger u_trig (
    .start_cpu (start_cpu),
    .start_ctl (start_ctl),
    .step      (step),
    .load      (load),
    .adv       (adv)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .adv      (adv),
    .start_in (ext_addr[BEAT_W-1:0]),
    .start_q  (start_q),
    .beat_q   (beat_q)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order     (order_e'(order_ilv)),
    .start_off (start_q),
    .beat      (beat_q),
    .low_out   (low_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    upper_q <= '0;
    else if (load) upper_q <= ext_addr[ADDR_W-1:BEAT_W];
  end

  assign burst_addr = {upper_q, low_out};

  // R2, R7: any strobe loads the external address on the next edge
  a_r2_strobe_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cpu || start_ctl) |=> (burst_addr == $past(ext_addr)));
  // R5: idle edge keeps the address
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_cpu && !start_ctl && !step) |=> $stable(burst_addr));
  // R6: upper bits only change on a strobe
  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_cpu && !start_ctl) |=> $stable(burst_addr[ADDR_W-1:BEAT_W]));
  // R3: linear step adds one modulo four
  a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_cpu && !start_ctl && step && !order_ilv)
      |=> (burst_addr[BEAT_W-1:0] == $past(burst_addr[BEAT_W-1:0]) + 2'd1));
endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          order_ilv = 1'b0;
  logic          start_cpu = 1'b0, start_ctl = 1'b0, step = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] burst_addr;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;   // 125 MHz

  burst_addr_seq #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .order_ilv(order_ilv),
    .start_cpu(start_cpu), .start_ctl(start_ctl), .step(step),
    .ext_addr(ext_addr), .burst_addr(burst_addr)
  );

  task automatic check(input string req, input logic [AW-1:0] exp);
    n_tests++;
    if (burst_addr !== exp) begin
      n_fail++;
      $display("FAIL %s: burst_addr=%h expected=%h", req, burst_addr, exp);
    end
  endtask

  // drive at negedge, apply at posedge, sample 1 ns after it
  task automatic cyc(input logic cpu, input logic ctl, input logic adv,
                     input logic [AW-1:0] a);
    @(negedge clk);
    start_cpu = cpu; start_ctl = ctl; step = adv; ext_addr = a;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [1:0] beat_low(input logic ilv, input logic [1:0] s,
                                          input int k);
    logic [1:0] kk;
    kk = 2'(k % 4);
    return ilv ? (s ^ kk) : 2'(s + kk);
  endfunction

  task automatic do_reset(input logic ilv);
    @(negedge clk);
    rst_n = 1'b0; order_ilv = ilv;
    start_cpu = 0; start_ctl = 0; step = 0; ext_addr = '1;
    @(posedge clk); #1;
    check("R1 in reset", '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", '0);
  endtask

  initial begin : watchdog
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] base;
    logic [AW-1:0] cur;
    logic          ilv;
    for (int m = 0; m < 2; m++) begin
      ilv = 1'(m);
      do_reset(ilv);
      for (int s = 0; s < 4; s++) begin
        for (int p = 0; p < 3; p++) begin
          base = AW'((((s * 13 + m * 7 + p * 3 + 5) % 64) << 2) | s);
          cyc(p != 1, p != 0, 1'b0, base);
          check("R2 strobe load", base);
          for (int k = 1; k <= 8; k++) begin
            if (k == 3) begin
              cur = burst_addr;
              cyc(1'b0, 1'b0, 1'b0, ~base);
              check("R5 idle hold", cur);
            end
            cyc(1'b0, 1'b0, 1'b1, ~base);
            check(ilv ? (k >= 4 ? "R8 R4 interleave wrap" : "R4 R6 interleave")
                      : (k >= 4 ? "R8 R3 linear wrap" : "R3 R6 linear"),
                  {base[AW-1:2], beat_low(ilv, base[1:0], k)});
          end
        end
      end
      // R7: restart mid-burst with step also high
      cyc(1'b1, 1'b0, 1'b0, 8'h25);
      cyc(1'b0, 1'b0, 1'b1, 8'h00);
      cyc(1'b0, 1'b0, 1'b1, 8'h00);
      check("R7 pre-restart", {6'h09, beat_low(ilv, 2'b01, 2)});
      cyc(1'b0, 1'b1, 1'b1, 8'hC2);
      check("R7 restart wins over step", 8'hC2);
      for (int k = 1; k <= 3; k++) begin
        cyc(1'b0, 1'b0, 1'b1, 8'hFF);
        check("R7 fresh beat count", {6'h30, beat_low(ilv, 2'b10, k)});
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule